// File: doc/BRIEF.md
# PCI Configuration Access Engine

This block takes one configuration request at a time and turns it into word-aligned accesses on a simple memory-mapped downstream port. A request names a bus, device, function, register offset, byte count (1, 2 or 4), direction and write data. For bus 0 the engine selects the target slot with a one-hot select bit. The high part of that one-hot pattern goes into a window register, which the engine drives out so that the downstream fabric can steer the access. The low part is merged into the access address. For any other bus it builds a bus/device/function address and loads the window with a second code.

Reads return the addressed bytes, moved down to bit 0 and cut to the requested size. A 1- or 2-byte write reads the containing word, replaces only the addressed lanes and stores the word back. A 4-byte write is a single store. Malformed or unreachable requests are refused without touching the downstream port. A bus error on the downstream port ends the request and returns all-ones data. A card-slot option limits bus traffic to device 0.

Top module: `cfg_window_engine`

## Requirements
- R1: A request with bus 0 and device d below SLOT_COUNT (default 16) issues its access at CFG_BASE | (bit (d+16) masked to the low WIN_LOW_BITS bits) | function<<8 | offset with bits 1:0 cleared. After the response, `win_cfg` equals WIN_CODE_T0 OR-ed with bit (d+16) masked to bits WIN_LOW_BITS and above.
- R2: A request with a nonzero bus issues its access at CFG_BASE | bus<<16 | device<<11 | function<<8 | offset with bits 1:0 cleared, and loads `win_cfg` with WIN_CODE_T1.
- R3: Each of the following is refused with `rsp_err`=1 and `rsp_rdata`=0, with no downstream transfer and `win_cfg` unchanged: a size other than 1, 2 or 4; bus 0 with device at or above SLOT_COUNT; `cardbus_mode`=1 with any device other than 0.
- R4: A successful read returns the fetched word shifted right by 8×(offset mod 4), then masked to 8 bits (size 1), 16 bits (size 2) or 32 bits (size 4), with `rsp_err`=0.
- R5: A 1- or 2-byte write performs a read, then a write to the same address. The written word is the read word with the addressed 8 or 16 bits, starting at bit 8×(offset mod 4), replaced by the low bits of `req_wdata`. The response has `rsp_err`=0 and `rsp_rdata`=0.
- R6: A 4-byte write performs exactly one downstream write of `req_wdata`, with no read.
- R7: A downstream bus error, signalled by `dn_berr` together with `dn_ready`, ends the request on the next cycle with `rsp_err`=1 and `rsp_rdata`=32'hFFFFFFFF. If the error occurs in the read phase of a sub-word write, no write follows.
- R8: A request is taken only when `req_valid` is high and `busy` is low. `busy` stays high from the cycle after acceptance through the single `rsp_valid` cycle and falls in the cycle after it. While `busy` is low, `dn_valid` and `rsp_valid` are low.
- R9: After reset, `busy`, `rsp_valid` and `dn_valid` are low and `win_cfg` equals WIN_CODE_T0.
- R10: While `dn_valid` is high and `dn_ready` is low, `dn_addr`, `dn_write` and `dn_wdata` hold their values into the next cycle, and `dn_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cardbus_mode | input | 1 | Restrict access to device 0 |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | OFF_W | Register byte offset |
| req_size | input | 3 | Byte count, 1, 2 or 4 |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request refused or bus error |
| rsp_rdata | output | 32 | Read data, right-aligned |
| win_cfg | output | 32 | Configuration window register value |
| dn_valid | output | 1 | Downstream access request |
| dn_write | output | 1 | Downstream access is a write |
| dn_addr | output | 32 | Downstream word address |
| dn_wdata | output | 32 | Downstream write word |
| dn_ready | input | 1 | Downstream access completes |
| dn_rdata | input | 32 | Downstream read word, valid with dn_ready |
| dn_berr | input | 1 | Downstream bus error, valid with dn_ready |

## Verification
The checker watches the request handshake, the downstream hold rule and the response rules on every cycle: one response per accepted request, and busy clear afterwards. It also checks that a bus error is answered by an all-ones error response, and that a clean read phase of a sub-word write is always followed by a write to the same address. The content of that written word, the Type 0 and Type 1 address layouts, the one-hot split between address and window, and the byte-lane extraction can only be shown by the bench's scenarios against its memory model. The same holds for refusals that leave the window untouched, and for the card-slot restriction.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
   localparam int DATA_W     = 32;
   localparam int BUS_W      = 8;
   localparam int DEV_W      = 5;
   localparam int FN_W       = 3;
   localparam int BUS_SHIFT  = 16;
   localparam int DEV_SHIFT  = 11;
   localparam int FN_SHIFT   = 8;
   localparam int IDSEL_BASE = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_RESP = 2'd3
   } eng_state_t;

   function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] sz);
      case (sz)
         3'd1:    size_mask = 32'h0000_00FF;
         3'd2:    size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction
endpackage

// File: rtl/cfgwin_addr_gen.sv
module cfgwin_addr_gen
   import cfgwin_pkg::*;
#(
   parameter logic [31:0] CFG_BASE     = 32'h0C00_0000,
   parameter int          WIN_LOW_BITS = 26,
   parameter logic [31:0] WIN_CODE_T0  = 32'h0000_0002,
   parameter logic [31:0] WIN_CODE_T1  = 32'h0000_0003,
   parameter int          SLOT_COUNT   = 16,
   parameter bit          HAS_CARDBUS  = 1'b1,
   parameter int          OFF_W        = 8
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FN_W-1:0]   fn,
   input  logic [OFF_W-1:2]  off_word,
   input  logic [2:0]        size,
   input  logic              cardbus,
   output logic              reject,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] win_val
);
   localparam logic [DATA_W-1:0] LOW_MASK = (32'd1 << WIN_LOW_BITS) - 32'd1;

   logic              type0;
   logic              size_ok;
   logic              slot_ok;
   logic              card_block;
   logic [5:0]        sel_pos;
   logic [DATA_W-1:0] onehot;
   logic [DATA_W-1:0] off_al;

   generate
      if (HAS_CARDBUS) begin : g_card
         assign card_block = cardbus && (dev != '0);
      end else begin : g_nocard
         assign card_block = 1'b0;
      end
   endgenerate

   always_comb begin
      type0   = (bus == '0);
      size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
      slot_ok = !type0 || (int'(dev) < SLOT_COUNT);
      reject  = !size_ok || !slot_ok || card_block;
      sel_pos = {1'b0, dev} + 6'(IDSEL_BASE);
      onehot  = 32'd1 << sel_pos;
      off_al  = DATA_W'({off_word, 2'b00});
      if (type0) begin
         addr    = CFG_BASE | (onehot & LOW_MASK) | (DATA_W'(fn) << FN_SHIFT) | off_al;
         win_val = WIN_CODE_T0 | (onehot & ~LOW_MASK);
      end else begin
         addr    = CFG_BASE | (DATA_W'(bus) << BUS_SHIFT) | (DATA_W'(dev) << DEV_SHIFT)
                 | (DATA_W'(fn) << FN_SHIFT) | off_al;
         win_val = WIN_CODE_T1;
      end
   end
endmodule

// File: rtl/cfgwin_lane.sv
module cfgwin_lane
   import cfgwin_pkg::*;
(
   input  logic [1:0]        byte_ofs,
   input  logic [2:0]        size,
   input  logic [DATA_W-1:0] word,
   input  logic [DATA_W-1:0] new_data,
   output logic [DATA_W-1:0] rd_val,
   output logic [DATA_W-1:0] merged
);
   logic [4:0]        sh;
   logic [DATA_W-1:0] szm;

   always_comb begin
      sh     = {byte_ofs, 3'b000};
      szm    = size_mask(size);
      rd_val = (word >> sh) & szm;
      if (size == 3'd4)
         merged = new_data;
      else
         merged = (word & ~(szm << sh)) | ((new_data & szm) << sh);
   end
endmodule

// File: rtl/cfg_window_engine.sv
module cfg_window_engine
   import cfgwin_pkg::*;
#(
   parameter logic [31:0] CFG_BASE     = 32'h0C00_0000,
   parameter int          WIN_LOW_BITS = 26,
   parameter logic [31:0] WIN_CODE_T0  = 32'h0000_0002,
   parameter logic [31:0] WIN_CODE_T1  = 32'h0000_0003,
   parameter int          SLOT_COUNT   = 16,
   parameter bit          HAS_CARDBUS  = 1'b1,
   parameter int          OFF_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cardbus_mode,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [7:0]        req_bus,
   input  logic [4:0]        req_dev,
   input  logic [2:0]        req_func,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [2:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic [31:0]       win_cfg,
   output logic              dn_valid,
   output logic              dn_write,
   output logic [31:0]       dn_addr,
   output logic [31:0]       dn_wdata,
   input  logic              dn_ready,
   input  logic [31:0]       dn_rdata,
   input  logic              dn_berr
);
   generate
      if (SLOT_COUNT < 1 || SLOT_COUNT > 16) begin : g_bad_slots
         $error("SLOT_COUNT must lie in 1..16");
      end
      if (WIN_LOW_BITS < 17 || WIN_LOW_BITS > 31) begin : g_bad_split
         $error("WIN_LOW_BITS must lie in 17..31");
      end
      if (OFF_W < 2 || OFF_W > 8) begin : g_bad_off
         $error("OFF_W must lie in 2..8");
      end
   endgenerate

   eng_state_t        state_q;
   logic              wr_q;
   logic [1:0]        ofs_q;
   logic [2:0]        size_q;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] win_q;
   logic              err_q;
   logic [DATA_W-1:0] rdata_q;

   logic              g_reject;
   logic [DATA_W-1:0] g_addr;
   logic [DATA_W-1:0] g_win;
   logic [DATA_W-1:0] l_rd;
   logic [DATA_W-1:0] l_merged;
   logic              accept;

   cfgwin_addr_gen #(
      .CFG_BASE     (CFG_BASE),
      .WIN_LOW_BITS (WIN_LOW_BITS),
      .WIN_CODE_T0  (WIN_CODE_T0),
      .WIN_CODE_T1  (WIN_CODE_T1),
      .SLOT_COUNT   (SLOT_COUNT),
      .HAS_CARDBUS  (HAS_CARDBUS),
      .OFF_W        (OFF_W)
   ) u_addr (
      .bus      (req_bus),
      .dev      (req_dev),
      .fn       (req_func),
      .off_word (req_off[OFF_W-1:2]),
      .size     (req_size),
      .cardbus  (cardbus_mode),
      .reject   (g_reject),
      .addr     (g_addr),
      .win_val  (g_win)
   );

   cfgwin_lane u_lane (
      .byte_ofs (ofs_q),
      .size     (size_q),
      .word     (dn_rdata),
      .new_data (wdata_q),
      .rd_val   (l_rd),
      .merged   (l_merged)
   );

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign busy      = (state_q != ST_IDLE);
   assign rsp_valid = (state_q == ST_RESP);
   assign rsp_err   = err_q;
   assign rsp_rdata = rdata_q;
   assign win_cfg   = win_q;
   assign dn_valid  = (state_q == ST_RD) || (state_q == ST_WR);
   assign dn_write  = (state_q == ST_WR);
   assign dn_addr   = addr_q;
   assign dn_wdata  = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         ofs_q   <= '0;
         size_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         win_q   <= WIN_CODE_T0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  wr_q    <= req_write;
                  ofs_q   <= req_off[1:0];
                  size_q  <= req_size;
                  addr_q  <= g_addr;
                  wdata_q <= req_wdata;
                  if (g_reject) begin
                     err_q   <= 1'b1;
                     rdata_q <= '0;
                     state_q <= ST_RESP;
                  end else begin
                     win_q   <= g_win;
                     state_q <= (req_write && req_size == 3'd4) ? ST_WR : ST_RD;
                  end
               end
            end
            ST_RD: begin
               if (dn_ready) begin
                  if (dn_berr) begin
                     err_q   <= 1'b1;
                     rdata_q <= '1;
                     state_q <= ST_RESP;
                  end else if (wr_q) begin
                     wdata_q <= l_merged;
                     state_q <= ST_WR;
                  end else begin
                     err_q   <= 1'b0;
                     rdata_q <= l_rd;
                     state_q <= ST_RESP;
                  end
               end
            end
            ST_WR: begin
               if (dn_ready) begin
                  err_q   <= dn_berr;
                  rdata_q <= dn_berr ? '1 : '0;
                  state_q <= ST_RESP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic        busy,
   input logic        rsp_valid,
   input logic        rsp_err,
   input logic [31:0] rsp_rdata,
   input logic        dn_valid,
   input logic        dn_write,
   input logic [31:0] dn_addr,
   input logic [31:0] dn_wdata,
   input logic        dn_ready,
   input logic        dn_berr
);
   logic pend_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_wr <= 1'b0;
      else if (req_valid && !busy)
         pend_wr <= req_write;
   end

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !busy |=> busy); // R8

   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !busy && !rsp_valid); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !dn_valid && !rsp_valid); // R8

   AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)); // R10

   AST_BERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && dn_ready && dn_berr |=> rsp_valid && rsp_err && (rsp_rdata == 32'hFFFF_FFFF)); // R7

   AST_RMW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && dn_ready && !dn_berr && !dn_write && pend_wr |=> dn_valid && dn_write && $stable(dn_addr)); // R5
endmodule

bind cfg_window_engine cfg_window_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .busy      (busy),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .dn_valid  (dn_valid),
   .dn_write  (dn_write),
   .dn_addr   (dn_addr),
   .dn_wdata  (dn_wdata),
   .dn_ready  (dn_ready),
   .dn_berr   (dn_berr)
);

// File: tb/cfg_window_engine_tb_top.sv
module cfg_window_engine_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          WD_LIMIT   = 20000;
   localparam logic [31:0] MEM_DEF    = 32'h4433_2211;

   typedef struct packed {
      logic        wr;
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [7:0]  off;
      logic [2:0]  size;
      logic [31:0] wdata;
      logic        err;
      logic [31:0] data;
      logic [31:0] addr;
      logic [31:0] win;
      logic [1:0]  ntx;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'd0, 5'd0,  3'd0, 8'h00, 3'd0 + 3'd4, 32'h0, 1'b0, 32'h4433_2211, 32'h0C01_0000, 32'h0000_0002, 2'd1},
      '{1'b0, 8'd0, 5'd3,  3'd1, 8'h0E, 3'd2, 32'h0,          1'b0, 32'h0000_4433, 32'h0C08_010C, 32'h0000_0002, 2'd1},
      '{1'b0, 8'd0, 5'd10, 3'd0, 8'h05, 3'd1, 32'h0,          1'b0, 32'h0000_0022, 32'h0C00_0004, 32'h0400_0002, 2'd1},
      '{1'b0, 8'd0, 5'd15, 3'd7, 8'h3F, 3'd1, 32'h0,          1'b0, 32'h0000_0044, 32'h0C00_073C, 32'h8000_0002, 2'd1},
      '{1'b0, 8'd2, 5'd5,  3'd3, 8'h10, 3'd4, 32'h0,          1'b0, 32'h4433_2211, 32'h0C02_2B10, 32'h0000_0003, 2'd1},
      '{1'b1, 8'd1, 5'd0,  3'd0, 8'h42, 3'd2, 32'h0000_BEEF,  1'b0, 32'h0,         32'h0C01_0040, 32'h0000_0003, 2'd2},
      '{1'b0, 8'd1, 5'd0,  3'd0, 8'h40, 3'd4, 32'h0,          1'b0, 32'hBEEF_2211, 32'h0C01_0040, 32'h0000_0003, 2'd1},
      '{1'b1, 8'd0, 5'd1,  3'd0, 8'h08, 3'd1, 32'h1234_5677,  1'b0, 32'h0,         32'h0C02_0008, 32'h0000_0002, 2'd2},
      '{1'b0, 8'd0, 5'd1,  3'd0, 8'h08, 3'd4, 32'h0,          1'b0, 32'h4433_2277, 32'h0C02_0008, 32'h0000_0002, 2'd1},
      '{1'b1, 8'd0, 5'd2,  3'd0, 8'h0C, 3'd4, 32'hDEAD_BEEF,  1'b0, 32'h0,         32'h0C04_000C, 32'h0000_0002, 2'd1},
      '{1'b0, 8'd0, 5'd2,  3'd0, 8'h0D, 3'd2, 32'h0,          1'b0, 32'h0000_ADBE, 32'h0C04_000C, 32'h0000_0002, 2'd1},
      '{1'b0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 32'h0,          1'b1, 32'h0,         32'h0C04_000C, 32'h0000_0002, 2'd0},
      '{1'b0, 8'd0, 5'd0,  3'd0, 8'h00, 3'd3, 32'h0,          1'b1, 32'h0,         32'h0C04_000C, 32'h0000_0002, 2'd0},
      '{1'b1, 8'd4, 5'd0,  3'd0, 8'h00, 3'd0, 32'h0,          1'b1, 32'h0,         32'h0C04_000C, 32'h0000_0002, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cardbus_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [7:0]  req_off = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        busy, rsp_valid, rsp_err;
   logic [31:0] rsp_rdata, win_cfg;
   logic        dn_valid, dn_write;
   logic [31:0] dn_addr, dn_wdata;
   logic        dn_ready = 1'b0;
   logic [31:0] dn_rdata = '0;
   logic        dn_berr = 1'b0;

   logic        berr_en = 1'b0;
   logic [31:0] berr_addr = '0;
   logic [31:0] mem [logic [31:0]];
   int          tx_total = 0;
   logic [31:0] last_addr = '0;
   int          cyc = 0;
   logic        timed_out = 1'b0;
   int          n_chk = 0;
   int          n_bad = 0;

   cfg_window_engine dut_i (
      .clk (clk), .rst_n (rst_n), .cardbus_mode (cardbus_mode),
      .req_valid (req_valid), .req_write (req_write), .req_bus (req_bus),
      .req_dev (req_dev), .req_func (req_func), .req_off (req_off),
      .req_size (req_size), .req_wdata (req_wdata),
      .busy (busy), .rsp_valid (rsp_valid), .rsp_err (rsp_err),
      .rsp_rdata (rsp_rdata), .win_cfg (win_cfg),
      .dn_valid (dn_valid), .dn_write (dn_write), .dn_addr (dn_addr),
      .dn_wdata (dn_wdata), .dn_ready (dn_ready), .dn_rdata (dn_rdata),
      .dn_berr (dn_berr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc >= WD_LIMIT) timed_out <= 1'b1;
   end

   // Downstream target model: one wait cycle, then a ready pulse.
   always @(posedge clk) begin
      if (!rst_n) begin
         dn_ready <= 1'b0;
         dn_berr  <= 1'b0;
      end else if (dn_valid && !dn_ready) begin
         dn_ready <= 1'b1;
         dn_rdata <= mem.exists(dn_addr) ? mem[dn_addr] : MEM_DEF;
         dn_berr  <= berr_en && (dn_addr == berr_addr);
      end else begin
         if (dn_valid && dn_ready) begin
            tx_total  <= tx_total + 1;
            last_addr <= dn_addr;
            if (dn_write && !dn_berr) mem[dn_addr] = dn_wdata;
         end
         dn_ready <= 1'b0;
         dn_berr  <= 1'b0;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_req(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                          input logic [2:0] fn, input logic [7:0] off, input logic [2:0] size,
                          input logic [31:0] wd, output logic e, output logic [31:0] d,
                          output int ntx);
      int start;
      while (busy && !timed_out) @(negedge clk);
      @(negedge clk);
      start     = tx_total;
      req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
      req_func  = fn;   req_off = off;  req_size = size; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid && !timed_out) @(negedge clk);
      e = rsp_err;
      d = rsp_rdata;
      @(negedge clk);
      ntx = tx_total - start;
   endtask

   initial begin
      logic        e;
      logic [31:0] d;
      int          ntx;
      int          start;

      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 busy", {31'b0, busy}, 32'd0);
      check("R9 rsp_valid", {31'b0, rsp_valid}, 32'd0);
      check("R9 dn_valid", {31'b0, dn_valid}, 32'd0);
      check("R9 win_cfg", win_cfg, 32'h0000_0002);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_req(VECS[i].wr, VECS[i].bus, VECS[i].dev, VECS[i].fn, VECS[i].off,
                 VECS[i].size, VECS[i].wdata, e, d, ntx);
         check($sformatf("R3_R7 err vec %0d", i), {31'b0, e}, {31'b0, VECS[i].err});
         check($sformatf("R4_R5_R6 data vec %0d", i), d, VECS[i].data);
         check($sformatf("R5_R6 transfers vec %0d", i), ntx, {30'b0, VECS[i].ntx});
         check($sformatf("R1_R2 addr vec %0d", i), last_addr, VECS[i].addr);
         check($sformatf("R1_R2_R3 window vec %0d", i), win_cfg, VECS[i].win);
      end

      // R8: request held while busy is not taken twice
      while (busy && !timed_out) @(negedge clk);
      start     = tx_total;
      req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd0; req_dev = 5'd0;
      req_func  = 3'd0; req_off = 8'h00; req_size = 3'd4; req_wdata = '0;
      @(negedge clk);
      check("R8 busy after accept", {31'b0, busy}, 32'd1);
      req_write = 1'b1; req_wdata = 32'h0BAD_0BAD; req_off = 8'h20;
      while (!rsp_valid && !timed_out) @(negedge clk);
      req_valid = 1'b0;
      check("R8 response data", rsp_rdata, 32'h4433_2211);
      @(negedge clk);
      check("R8 busy after response", {31'b0, busy}, 32'd0);
      check("R8 single transfer", tx_total - start, 32'd1);

      // R3: card-slot restriction
      cardbus_mode = 1'b1;
      run_req(1'b0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd4, 32'h0, e, d, ntx);
      check("R3 cardbus dev1 err", {31'b0, e}, 32'd1);
      check("R3 cardbus dev1 transfers", ntx, 32'd0);
      run_req(1'b0, 8'd3, 5'd2, 3'd0, 8'h00, 3'd4, 32'h0, e, d, ntx);
      check("R3 cardbus bus3 err", {31'b0, e}, 32'd1);
      check("R3 cardbus bus3 window", win_cfg, 32'h0000_0002);
      run_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 32'h0, e, d, ntx);
      check("R3 cardbus dev0 data", d, 32'h4433_2211);
      cardbus_mode = 1'b0;

      // R7: bus errors
      berr_addr = 32'h0C01_0000;
      berr_en   = 1'b1;
      run_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h01, 3'd1, 32'h0, e, d, ntx);
      check("R7 read err", {31'b0, e}, 32'd1);
      check("R7 read data", d, 32'hFFFF_FFFF);
      run_req(1'b1, 8'd0, 5'd0, 3'd0, 8'h02, 3'd1, 32'h77, e, d, ntx);
      check("R7 rmw err", {31'b0, e}, 32'd1);
      check("R7 rmw data", d, 32'hFFFF_FFFF);
      check("R7 rmw no write phase", ntx, 32'd1);
      berr_en = 1'b0;
      run_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 32'h0, e, d, ntx);
      check("R7 word untouched", d, 32'h4433_2211);

      // R2: type 1 with maximal fields
      run_req(1'b0, 8'hFF, 5'd31, 3'd7, 8'hFC, 3'd4, 32'h0, e, d, ntx);
      check("R2 max field addr", last_addr, 32'h0CFF_FFFC);
      check("R2 max field window", win_cfg, 32'h0000_0003);

      if (timed_out) begin
         n_bad++;
         $display("FAIL watchdog actual %0d expected below %0d", cyc, WD_LIMIT);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait (timed_out);
      #(CLK_PERIOD * 200);
      n_bad++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule